// File: doc/BRIEF.md
# Address-Window Decoder for a Dual Event-Counter Snapshot Unit

This block sits between a simple byte-wide bus and a dual 16-bit event-counter unit that holds a 32-bit snapshot register. It claims eight consecutive byte addresses, picked by three low address bits. The window is live only while one active-high enable is high and two active-low chip enables are both low. Inside the window, four offsets read the four bytes of the saved counts. One offset requests a new snapshot, one clears both counters, and the last two are spare.

The block turns each access into the signals the counter unit expects. For byte reads it drives a one-hot byte select and returns the byte the unit presents, with an output-enable flag. For control offsets it issues a single-cycle capture strobe or a stretched clear strobe. Every strobe and select comes from a flip-flop, so the counter unit never sees a decode glitch. The byte selects also respect a minimum all-idle interval before any of them is driven active again.

Top module: `mapped_ctr_window`

## Requirements
- R1: The window is live only when `bus_en_i` is 1 and both `bus_ce0_n_i` and `bus_ce1_n_i` are 0. In any other combination, no byte select, capture strobe or clear strobe is produced and `rd_oe_o` stays 0.
- R2: A live access at offset 0, 1, 2 or 3 drives `byte_sel_o` bit 0, 1, 2 or 3 respectively (bit 0 = counter A low byte, 1 = A high, 2 = B low, 3 = B high) from the clock edge after the access is sampled, provided the idle rule R6 is met. While a select is driven, `rd_oe_o` is 1 and `rd_data_o` equals `cnt_byte_i`.
- R3: An access at offset 4 raises `snap_o` for exactly one cycle, beginning on the clock edge after the access starts. This happens once per access however long the window is held, and no byte select is driven.
- R4: An access at offset 5 raises `clr_o` for exactly `CLR_MIN_CYC` consecutive cycles, once per access, and drives no byte select.
- R5: Offsets 6 and 7 produce no strobe and no select, and `rd_oe_o` stays 0.
- R6: Once all byte selects are released, they all stay 0 for at least `IDLE_MIN_CYC` cycles before any select is driven again. A read request that arrives during that interval waits for the interval to end.
- R7: A change of offset while the window stays live starts a new access.
- R8: While `rd_oe_o` is 0, `rd_data_o` is 0.
- R9: While reset is held and right after it, every output is 0.
- R10: At most one bit of `byte_sel_o` is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en_i | input | 1 | Active-high window enable |
| bus_ce0_n_i | input | 1 | First active-low chip enable |
| bus_ce1_n_i | input | 1 | Second active-low chip enable |
| bus_addr_i | input | 3 | Byte offset inside the window |
| cnt_byte_i | input | DATA_W | Byte presented by the counter unit for the active select |
| byte_sel_o | output | 4 | One-hot snapshot byte select towards the counter unit |
| snap_o | output | 1 | Capture strobe: save both counters into the snapshot register |
| clr_o | output | 1 | Stretched clear strobe for both counters |
| rd_data_o | output | DATA_W | Read data, 0 when not driven |
| rd_oe_o | output | 1 | Read data valid (bus driven) |

## Verification
The hardest case to create is a read that is requested while the idle interval is still running. Bus accesses usually leave gaps, and those gaps hide the rule. The stimulus therefore issues the four byte reads back to back: each new offset is presented on the cycle right after the previous byte was returned. This forces every select to wait, so the all-zero run between selects can be measured. A related case is an offset change while the window stays live, which the bench produces by stepping the address 4→6→4 and 4→5 without ever dropping the enables. To reach counter values whose upper half is non-zero, the bench counts more than 65,536 events in one burst before taking a snapshot.

// File: rtl/mcw_pkg.sv
package mcw_pkg;

   localparam int OFFS_W    = 3;
   localparam int NUM_BYTES = 4;

   // Offset map inside the eight-byte window; the read offsets index the bytes.
   typedef enum logic [OFFS_W-1:0] {
      OFF_A_LO  = 3'd0,
      OFF_A_HI  = 3'd1,
      OFF_B_LO  = 3'd2,
      OFF_B_HI  = 3'd3,
      OFF_SNAP  = 3'd4,
      OFF_CLEAR = 3'd5,
      OFF_SPR0  = 3'd6,
      OFF_SPR1  = 3'd7
   } win_off_e;

   function automatic logic is_read(win_off_e off);
      logic [OFFS_W-1:0] raw;
      raw = off;
      return ~raw[OFFS_W-1];
   endfunction

   function automatic logic [NUM_BYTES-1:0] byte_onehot(win_off_e off);
      logic [OFFS_W-1:0] raw;
      raw = off;
      return NUM_BYTES'(1) << raw[1:0];
   endfunction

endpackage

// File: rtl/mcw_win_decode.sv
module mcw_win_decode
   import mcw_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              ce0_n_i,
   input  logic              ce1_n_i,
   input  logic [OFFS_W-1:0] addr_i,
   output logic              hit_o,
   output logic              start_o,
   output win_off_e          off_o
);

   logic              act_q;
   logic [OFFS_W-1:0] addr_q;

   always_comb begin
      hit_o   = en_i & ~ce0_n_i & ~ce1_n_i;
      off_o   = win_off_e'(addr_i);
      // a new access: window just opened, or offset moved while it stayed open
      start_o = hit_o & (~act_q | (addr_i != addr_q));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         addr_q <= '0;
      end else begin
         act_q  <= hit_o;
         addr_q <= addr_i;
      end
   end

   // R7: a start inside a held window needs a different offset than last cycle
   a_r7_restart_on_move: assert property (@(posedge clk) disable iff (!rst_n)
      (start_o && act_q) |-> (addr_i != addr_q));

endmodule

// File: rtl/mcw_strobe_gen.sv
module mcw_strobe_gen
   import mcw_pkg::*;
#(
   parameter int CLR_MIN_CYC = 4
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start_i,
   input  win_off_e off_i,
   output logic     snap_o,
   output logic     clr_o
);

   localparam int CW = $clog2(CLR_MIN_CYC + 1);

   logic snap_q;

   always_ff @(posedge clk) begin
      if (!rst_n) snap_q <= 1'b0;
      else        snap_q <= start_i && (off_i == OFF_SNAP);
   end
   assign snap_o = snap_q;

   generate
      if (CLR_MIN_CYC == 1) begin : g_clr_single
         logic clr_q;
         always_ff @(posedge clk) begin
            if (!rst_n) clr_q <= 1'b0;
            else        clr_q <= start_i && (off_i == OFF_CLEAR);
         end
         assign clr_o = clr_q;
      end else begin : g_clr_stretch
         logic [CW-1:0] left_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               left_q <= '0;
            else if (start_i && (off_i == OFF_CLEAR))
               left_q <= CW'(CLR_MIN_CYC);
            else if (left_q != '0)
               left_q <= left_q - 1'b1;
         end
         assign clr_o = (left_q != '0);
      end
   endgenerate

   // independent run-length counter for the clear width check
   logic [CW:0] clr_run;
   always_ff @(posedge clk) begin
      if (!rst_n)              clr_run <= '0;
      else if (!clr_o)         clr_run <= '0;
      else if (clr_run < (CW+1)'(CLR_MIN_CYC)) clr_run <= clr_run + 1'b1;
   end

   // R3: the capture strobe never lasts two cycles
   a_r3_snap_single: assert property (@(posedge clk) disable iff (!rst_n)
      snap_o |=> !snap_o);

   // R3: capture only follows the start of an access
   a_r3_snap_source: assert property (@(posedge clk) disable iff (!rst_n)
      snap_o |-> $past(start_i));

   // R4: every clear pulse lasts at least the configured width
   a_r4_clr_width: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clr_o) |-> (clr_run >= (CW+1)'(CLR_MIN_CYC)));

endmodule

// File: rtl/mcw_read_gate.sv
module mcw_read_gate
   import mcw_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int IDLE_MIN_CYC = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 hit_i,
   input  win_off_e             off_i,
   input  logic [DATA_W-1:0]    byte_i,
   output logic [NUM_BYTES-1:0] sel_o,
   output logic [DATA_W-1:0]    data_o,
   output logic                 oe_o
);

   localparam int IW = (IDLE_MIN_CYC < 1) ? 1 : $clog2(IDLE_MIN_CYC + 1);

   logic [NUM_BYTES-1:0] want, sel_q, sel_d;
   logic                 grant;

   always_comb begin
      want = (hit_i && is_read(off_i)) ? byte_onehot(off_i) : '0;
      if (want == '0)
         sel_d = '0;
      else if (sel_q == want)
         sel_d = want;                  // keep the byte already on the bus
      else if ((sel_q == '0) && grant)
         sel_d = want;                  // idle interval served
      else
         sel_d = '0;                    // drop first, then wait out the gap
   end

   always_ff @(posedge clk) begin
      if (!rst_n) sel_q <= '0;
      else        sel_q <= sel_d;
   end

   assign sel_o = sel_q;
   assign oe_o  = |sel_q;

   for (genvar b = 0; b < DATA_W; b++) begin : g_gate
      assign data_o[b] = byte_i[b] & oe_o;
   end

   generate
      if (IDLE_MIN_CYC == 0) begin : g_nogap
         assign grant = 1'b1;
      end else begin : g_gap
         logic [IW-1:0] idle_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               idle_q <= IW'(IDLE_MIN_CYC);
            else if (|sel_q)
               idle_q <= '0;
            else if (idle_q < IW'(IDLE_MIN_CYC))
               idle_q <= idle_q + 1'b1;
         end
         assign grant = (idle_q >= IW'(IDLE_MIN_CYC));

         // checker: length of the current all-zero run of the selects
         logic [IW:0] gap_run;
         always_ff @(posedge clk) begin
            if (!rst_n)
               gap_run <= (IW+1)'(IDLE_MIN_CYC);
            else if (|sel_o)
               gap_run <= '0;
            else if (gap_run < (IW+1)'(IDLE_MIN_CYC))
               gap_run <= gap_run + 1'b1;
         end

         // R6: a select only rises after the full idle interval
         a_r6_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(|sel_o) |-> (gap_run >= (IW+1)'(IDLE_MIN_CYC)));
      end
   endgenerate

   // R10: never more than one byte on the bus
   a_r10_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_o));

   // R2: a select can switch straight to a different byte only through zero
   a_r2_no_direct_swap: assert property (@(posedge clk) disable iff (!rst_n)
      ((|sel_o) && !$stable(sel_o)) |-> ($past(sel_o) == '0));

endmodule

// File: rtl/mapped_ctr_window.sv
module mapped_ctr_window
   import mcw_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int CLR_MIN_CYC  = 4,
   parameter int IDLE_MIN_CYC = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_en_i,
   input  logic                 bus_ce0_n_i,
   input  logic                 bus_ce1_n_i,
   input  logic [OFFS_W-1:0]    bus_addr_i,
   input  logic [DATA_W-1:0]    cnt_byte_i,
   output logic [NUM_BYTES-1:0] byte_sel_o,
   output logic                 snap_o,
   output logic                 clr_o,
   output logic [DATA_W-1:0]    rd_data_o,
   output logic                 rd_oe_o
);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("mapped_ctr_window: DATA_W must be at least 1");
      end
      if (CLR_MIN_CYC < 1) begin : g_bad_clr
         $error("mapped_ctr_window: CLR_MIN_CYC must be at least 1");
      end
      if (IDLE_MIN_CYC < 0) begin : g_bad_idle
         $error("mapped_ctr_window: IDLE_MIN_CYC must not be negative");
      end
   endgenerate

   logic     win_hit, win_start;
   win_off_e win_off;

   mcw_win_decode u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (bus_en_i),
      .ce0_n_i (bus_ce0_n_i),
      .ce1_n_i (bus_ce1_n_i),
      .addr_i  (bus_addr_i),
      .hit_o   (win_hit),
      .start_o (win_start),
      .off_o   (win_off)
   );

   mcw_strobe_gen #(.CLR_MIN_CYC(CLR_MIN_CYC)) u_strb (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (win_start),
      .off_i   (win_off),
      .snap_o  (snap_o),
      .clr_o   (clr_o)
   );

   mcw_read_gate #(.DATA_W(DATA_W), .IDLE_MIN_CYC(IDLE_MIN_CYC)) u_rd (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit_i  (win_hit),
      .off_i  (win_off),
      .byte_i (cnt_byte_i),
      .sel_o  (byte_sel_o),
      .data_o (rd_data_o),
      .oe_o   (rd_oe_o)
   );

   // R1: with the window closed last cycle nothing is selected or captured now
   a_r1_closed_window: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(win_hit) |-> ((byte_sel_o == '0) && !snap_o));

   // R2: a driven select comes from a live read offset one cycle earlier
   a_r2_sel_source: assert property (@(posedge clk) disable iff (!rst_n)
      (|byte_sel_o) |-> $past(win_hit && !bus_addr_i[OFFS_W-1]));

   // R4: a clear pulse starts only from a live access at the clear offset
   a_r4_clr_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clr_o) |-> $past(win_hit && (bus_addr_i == OFF_CLEAR)));

   // R8: released data is zero
   a_r8_released_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_oe_o |-> (rd_data_o == '0));

endmodule

// File: tb/mapped_ctr_window_tb_top.sv
`timescale 1ns/1ps
module mapped_ctr_window_tb_top;

   localparam int DW   = 8;
   localparam int CLRW = 4;
   localparam int IDLE = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0, ce0_n = 1'b1, ce1_n = 1'b1;
   logic [2:0] addr = '0;
   logic [7:0] cnt_byte;
   logic [3:0] byte_sel;
   logic       snap, clr, rd_oe;
   logic [7:0] rd_data;

   always #2 clk = ~clk;   // 250 MHz

   mapped_ctr_window #(.DATA_W(DW), .CLR_MIN_CYC(CLRW), .IDLE_MIN_CYC(IDLE)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_en_i(en), .bus_ce0_n_i(ce0_n), .bus_ce1_n_i(ce1_n),
      .bus_addr_i(addr), .cnt_byte_i(cnt_byte), .byte_sel_o(byte_sel), .snap_o(snap),
      .clr_o(clr), .rd_data_o(rd_data), .rd_oe_o(rd_oe));

   // Stand-in for the counter unit: both counters chained as one 32-bit count
   logic        ev = 1'b0;
   logic [31:0] cnt_q, store_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0; store_q <= '0;
      end else begin
         if (clr)      cnt_q <= '0;
         else if (ev)  cnt_q <= cnt_q + 1;
         if (snap)     store_q <= cnt_q;
      end
   end
   always_comb begin
      case (byte_sel)
         4'b0001: cnt_byte = store_q[7:0];
         4'b0010: cnt_byte = store_q[15:8];
         4'b0100: cnt_byte = store_q[23:16];
         4'b1000: cnt_byte = store_q[31:24];
         default: cnt_byte = 8'h00;
      endcase
   end

   int errors = 0, checks = 0;
   logic [31:0] ref_total = 0, ref_snap = 0;

   task automatic chk(input logic ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard
   logic [7:0] exp_q[$];
   int         idx_q[$];
   logic [7:0] got_b[4];
   int  snap_pulses = 0, clr_pulses = 0, clr_len = 0, last_clr_len = 0;
   int  zero_run = 0;
   logic prev_oe = 1'b0, seen_sel = 1'b0, prev_clr = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (snap) snap_pulses++;
         if (clr) clr_len++;
         else if (prev_clr) begin
            clr_pulses++; last_clr_len = clr_len; clr_len = 0;
         end
         prev_clr = clr;
         if (!rd_oe) begin
            chk(rd_data == 8'h00, "R8 released data", rd_data, 0);
            zero_run++;
         end else if (!prev_oe) begin
            if (seen_sel) chk(zero_run >= IDLE, "R6 idle gap", zero_run, IDLE);
            seen_sel = 1'b1;
            zero_run = 0;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R1/R5 unexpected read", byte_sel, 0);
            end else begin
               automatic logic [7:0] e = exp_q.pop_front();
               automatic int         ix = idx_q.pop_front();
               chk(byte_sel == (4'b1 << ix), "R2 byte select", byte_sel, 4'b1 << ix);
               chk(rd_data == e, "R2 read byte", rd_data, e);
               got_b[ix] = rd_data;
            end
         end
         prev_oe = rd_oe;
      end
   end

   task automatic open_win(input logic [2:0] a);
      en = 1'b1; ce0_n = 1'b0; ce1_n = 1'b0; addr = a;
   endtask
   task automatic close_win();
      en = 1'b0; ce0_n = 1'b1; ce1_n = 1'b1;
   endtask

   // back-to-back read: the offset is presented the cycle after the previous byte
   task automatic do_read(input int ix);
      exp_q.push_back(ref_snap[8*ix +: 8]);
      idx_q.push_back(ix);
      @(negedge clk) open_win(3'(ix));
      for (int w = 0; w < 40; w++) begin
         @(negedge clk);
         if (rd_oe) break;
      end
   endtask

   task automatic read32(input string tag);
      for (int i = 0; i < 4; i++) do_read(i);
      @(negedge clk) close_win();
      repeat (2) @(negedge clk);
      chk({got_b[3], got_b[2], got_b[1], got_b[0]} == ref_snap, tag,
          {got_b[3], got_b[2], got_b[1], got_b[0]}, ref_snap);
   endtask

   task automatic count_ev(input int n);
      @(negedge clk) ev = 1'b1;
      repeat (n) @(negedge clk);
      ev = 1'b0;
      ref_total = ref_total + n;
   endtask

   task automatic pulse_off(input logic [2:0] a, input int hold);
      @(negedge clk) open_win(a);
      repeat (hold) @(negedge clk);
      close_win();
      repeat (CLRW + 3) @(negedge clk);
   endtask

   task automatic take_snap();
      pulse_off(3'd4, 1);
      ref_snap = ref_total;
   endtask

   task automatic do_clear();
      pulse_off(3'd5, 1);
      ref_total = 0;
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int s0, c0;
      repeat (3) @(negedge clk);
      // R9: reset state
      chk({byte_sel, snap, clr, rd_oe, rd_data} == '0, "R9 during reset",
          {byte_sel, snap, clr, rd_oe, rd_data}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({byte_sel, snap, clr, rd_oe, rd_data} == '0, "R9 after reset",
          {byte_sel, snap, clr, rd_oe, rd_data}, 0);

      // R4: single clear pulse of the configured width
      c0 = clr_pulses;
      do_clear();
      chk(clr_pulses == c0 + 1, "R4 one clear pulse", clr_pulses - c0, 1);
      chk(last_clr_len == CLRW, "R4 clear width", last_clr_len, CLRW);

      // R2/R3: count, snapshot, read four bytes
      s0 = snap_pulses;
      count_ev(300);
      take_snap();
      chk(snap_pulses == s0 + 1, "R3 one capture", snap_pulses - s0, 1);
      read32("R2 value 300");

      // carry into the upper counter
      count_ev(65800);
      take_snap();
      read32("R2 value past 16 bits");

      // R1: closed-window combinations are ignored
      s0 = snap_pulses; c0 = clr_pulses;
      count_ev(17);
      @(negedge clk) begin open_win(3'd4); en = 1'b0; end
      repeat (3) @(negedge clk);
      @(negedge clk) begin open_win(3'd5); ce0_n = 1'b1; end
      repeat (3) @(negedge clk);
      @(negedge clk) begin open_win(3'd0); ce1_n = 1'b1; end
      repeat (5) @(negedge clk);
      close_win();
      repeat (CLRW + 2) @(negedge clk);
      chk(snap_pulses == s0, "R1 no capture when closed", snap_pulses - s0, 0);
      chk(clr_pulses == c0, "R1 no clear when closed", clr_pulses - c0, 0);
      read32("R1 old snapshot kept");
      take_snap();
      read32("R1 count not cleared");

      // R5: spare offsets
      s0 = snap_pulses; c0 = clr_pulses;
      count_ev(9);
      pulse_off(3'd6, 3);
      pulse_off(3'd7, 3);
      chk(snap_pulses == s0, "R5 no capture", snap_pulses - s0, 0);
      chk(clr_pulses == c0, "R5 no clear", clr_pulses - c0, 0);
      read32("R5 snapshot unchanged");

      // R3: held capture access fires once
      s0 = snap_pulses;
      pulse_off(3'd4, 6);
      ref_snap = ref_total;
      chk(snap_pulses == s0 + 1, "R3 held access single capture", snap_pulses - s0, 1);

      // R7: offset moves inside a held window
      s0 = snap_pulses;
      @(negedge clk) open_win(3'd4);
      repeat (2) @(negedge clk);
      addr = 3'd6;
      repeat (2) @(negedge clk);
      addr = 3'd4;
      repeat (2) @(negedge clk);
      close_win();
      repeat (3) @(negedge clk);
      chk(snap_pulses == s0 + 2, "R7 restart on offset move", snap_pulses - s0, 2);

      // R4 + R7: held clear once, then capture-to-clear hop
      c0 = clr_pulses;
      pulse_off(3'd5, 8);
      chk(clr_pulses == c0 + 1, "R4 held clear single pulse", clr_pulses - c0, 1);
      chk(last_clr_len == CLRW, "R4 held clear width", last_clr_len, CLRW);
      count_ev(5);
      s0 = snap_pulses; c0 = clr_pulses;
      @(negedge clk) open_win(3'd4);
      repeat (2) @(negedge clk);
      addr = 3'd5;
      repeat (2) @(negedge clk);
      close_win();
      repeat (CLRW + 3) @(negedge clk);
      chk(snap_pulses == s0 + 1, "R7 capture before hop", snap_pulses - s0, 1);
      chk(clr_pulses == c0 + 1, "R7 clear after hop", clr_pulses - c0, 1);
      ref_snap = 5;
      ref_total = 0;
      read32("R3 snapshot of 5 before clear");

      chk(exp_q.size() == 0, "R2 all reads returned", exp_q.size(), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule